// File: doc/BRIEF.md
# Pseudo-Static RAM Read Refresh-Starvation Monitor

A passive observer for the control and address pins of an asynchronous pseudo-static RAM. The memory hides its refresh behind normal read cycles. If reads keep moving to new addresses before a full read cycle time has elapsed, refresh can be starved. The monitor samples active-low chip enable, active-low write enable and the address bus on a fast reference clock. It measures how long each read address is held, and it times how long an unbroken run of too-short address intervals lasts. When that run outlasts the allowed window, it records a violation.

A run of short intervals is ended by either of two recovery events. The first is one proper read, where the address is held for a full read cycle time. The second is a chip-enable-high gap that lasts at least a read cycle time. Write activity is set aside: it neither ages the window nor recovers it. The violation flag is sticky until a synchronous clear, and a saturating counter tallies separate violations. Timing is set in picoseconds through parameters for the reference clock period, the read cycle time (55 ns or 70 ns grades) and the window (15 us). The monitor drives nothing onto the memory bus.

Top module: `psram_refresh_monitor`

## Requirements
- R1: After reset, `viol_flag` is 0 and `viol_count` is 0.
- R2: A read cycle has `mem_ce_n`=0 and `mem_we_n`=1. When the address changes during reading, and the previous address was held for fewer than TRC_CYC = ceil(TRC_PS/CLK_PS) consecutive read cycles, the interval is invalid. An invalid interval starts the window if the window is not already running. The first read cycle after chip enable falls begins a new interval and is never a change.
- R3: A running window advances by one on each non-write clock. When it completes WIN_CYC = ceil(WIN_PS/CLK_PS) advances with no recovery, a violation is recorded. `viol_flag` reads 1 on the next clock, and the window stops until the next invalid interval.
- R4: A read address held for TRC_CYC consecutive read cycles stops and clears a running window.
- R5: `mem_ce_n` held high for TRC_CYC consecutive cycles stops and clears the window. A shorter high gap does not, and the window keeps advancing through it.
- R6: While `mem_ce_n`=0 and `mem_we_n`=0, the window neither advances nor clears, and the address-hold measurement is frozen.
- R7: `viol_flag` stays 1 until `viol_clr` is sampled high. A violation in the same cycle as `viol_clr` leaves the flag set. `viol_clr` does not change `viol_count`.
- R8: `viol_count` rises by exactly 1 per violation and saturates at 2^CNT_W-1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference sampling clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mem_ce_n | input | 1 | Observed chip enable, active low |
| mem_we_n | input | 1 | Observed write enable, active low |
| mem_addr | input | ADDR_W | Observed address bus |
| viol_clr | input | 1 | Synchronous clear of the sticky flag |
| viol_flag | output | 1 | Sticky violation indicator |
| viol_count | output | CNT_W | Saturating count of violations |

## Verification
The assertions check several properties on every cycle. They confirm that at most one bus event is decoded per cycle, that write cycles leave the window untouched, and that the window age stays below its limit. They also confirm that either recovery event empties the window, that the flag is sticky and wins against a clear, and that the count moves only upward, one step at a time. Only the bench scenarios can show the overall timing. These cover where the read-cycle boundary falls (a hold of 17 versus 18 clocks), short versus long chip-enable gaps, write bursts placed inside a run, and counter saturation. Each is compared clock by clock against a behavioural model.

// File: rtl/psram_mon_pkg.sv
package psram_mon_pkg;

    typedef struct packed {
        logic invalid;   // short address interval ended
        logic normal;    // address held a full read cycle
        logic gap_done;  // chip enable high a full read cycle
    } rd_evt_t;

    function automatic int cdiv(input int num, input int den);
        return (num + den - 1) / den;
    endfunction

endpackage

// File: rtl/psram_rd_tracker.sv
module psram_rd_tracker
    import psram_mon_pkg::*;
#(
    parameter int ADDR_W  = 17,
    parameter int TRC_CYC = 18
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ce_n,
    input  logic              we_n,
    input  logic [ADDR_W-1:0] addr,
    output rd_evt_t           evt
);
    localparam int SW = $clog2(TRC_CYC + 1);
    localparam logic [SW-1:0] TOP  = SW'(TRC_CYC);
    localparam logic [SW-1:0] LAST = SW'(TRC_CYC - 1);
    localparam logic [SW-1:0] ONE  = SW'(1);

    typedef struct packed {
        logic [ADDR_W-1:0] addr;
        logic [SW-1:0]     hold;
        logic [SW-1:0]     gap;
    } trk_t;

    trk_t    s_d, s_q;
    rd_evt_t e_d;

    always_comb begin
        s_d = s_q;
        e_d = '0;
        if (ce_n) begin
            s_d.hold = '0;
            s_d.addr = addr;
            if (s_q.gap != TOP) s_d.gap = s_q.gap + ONE;
            e_d.gap_done = (s_q.gap == LAST);
        end else if (!we_n) begin
            s_d.gap = '0;
        end else begin
            s_d.gap  = '0;
            s_d.addr = addr;
            if (s_q.hold == '0) begin
                s_d.hold = ONE;
            end else if (addr != s_q.addr) begin
                e_d.invalid = (s_q.hold < TOP);
                s_d.hold    = ONE;
            end else begin
                if (s_q.hold != TOP) s_d.hold = s_q.hold + ONE;
                e_d.normal = (s_q.hold == LAST);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign evt = e_d;

    a_r2_single_event: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(evt));
    a_r6_write_silent: assert property (@(posedge clk) disable iff (!rst_n)
        (!ce_n && !we_n) |-> (evt == '0));
    a_r5_gap_follows_high: assert property (@(posedge clk) disable iff (!rst_n)
        evt.gap_done |-> (ce_n && $past(ce_n)));

endmodule

// File: rtl/psram_win_timer.sv
module psram_win_timer
    import psram_mon_pkg::*;
#(
    parameter int WIN_CYC = 3750
) (
    input  logic    clk,
    input  logic    rst_n,
    input  rd_evt_t evt,
    input  logic    frozen,
    output logic    expire
);
    localparam int WW = $clog2(WIN_CYC + 1);
    localparam logic [WW-1:0] WLAST = WW'(WIN_CYC - 1);
    localparam logic [WW-1:0] WONE  = WW'(1);

    typedef struct packed {
        logic          act;
        logic [WW-1:0] age;
    } win_t;

    win_t s_d, s_q;
    logic exp_d;
    logic restart;

    assign restart = evt.normal | evt.gap_done;

    always_comb begin
        s_d   = s_q;
        exp_d = 1'b0;
        if (restart) begin
            s_d = '0;
        end else if (s_q.act && !frozen) begin
            if (s_q.age == WLAST) begin
                exp_d = 1'b1;
                s_d   = '0;
            end else begin
                s_d.age = s_q.age + WONE;
            end
        end else if (!s_q.act && evt.invalid) begin
            s_d.act = 1'b1;
            s_d.age = '0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign expire = exp_d;

    a_r3_age_bound: assert property (@(posedge clk) disable iff (!rst_n)
        s_q.age <= WLAST);
    a_r4_restart_clears: assert property (@(posedge clk) disable iff (!rst_n)
        restart |=> (!s_q.act && s_q.age == '0));
    a_r6_frozen_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (frozen && !restart) |=> ($stable(s_q.age) && $stable(s_q.act)));
    a_r3_idle_age_zero: assert property (@(posedge clk) disable iff (!rst_n)
        !s_q.act |-> (s_q.age == '0));

endmodule

// File: rtl/psram_viol_recorder.sv
module psram_viol_recorder #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             expire,
    input  logic             clr,
    output logic             flag,
    output logic [CNT_W-1:0] count
);
    localparam logic [CNT_W-1:0] CMAX = {CNT_W{1'b1}};
    localparam logic [CNT_W-1:0] CONE = CNT_W'(1);

    typedef struct packed {
        logic             flag;
        logic [CNT_W-1:0] cnt;
    } rec_t;

    rec_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        if (expire) begin
            s_d.flag = 1'b1;
            if (s_q.cnt != CMAX) s_d.cnt = s_q.cnt + CONE;
        end else if (clr) begin
            s_d.flag = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign flag  = s_q.flag;
    assign count = s_q.cnt;

    a_r7_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (flag && !clr) |=> flag);
    a_r7_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
        expire |=> flag);
    a_r8_monotone: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (count >= $past(count)));
    a_r8_single_step: assert property (@(posedge clk) disable iff (!rst_n)
        (count != $past(count)) |-> (flag && count == $past(count) + CONE));

endmodule

// File: rtl/psram_refresh_monitor.sv
module psram_refresh_monitor
    import psram_mon_pkg::*;
#(
    parameter int ADDR_W = 17,
    parameter int CNT_W  = 8,
    parameter int CLK_PS = 4000,
    parameter int TRC_PS = 70000,
    parameter int WIN_PS = 15000000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              mem_ce_n,
    input  logic              mem_we_n,
    input  logic [ADDR_W-1:0] mem_addr,
    input  logic              viol_clr,
    output logic              viol_flag,
    output logic [CNT_W-1:0]  viol_count
);
    localparam int TRC_CYC = cdiv(TRC_PS, CLK_PS);
    localparam int WIN_CYC = cdiv(WIN_PS, CLK_PS);

    rd_evt_t evt;
    logic    expire;
    logic    wr_cyc;

    assign wr_cyc = !mem_ce_n && !mem_we_n;

    psram_rd_tracker #(.ADDR_W(ADDR_W), .TRC_CYC(TRC_CYC)) u_trk (
        .clk   (clk),
        .rst_n (rst_n),
        .ce_n  (mem_ce_n),
        .we_n  (mem_we_n),
        .addr  (mem_addr),
        .evt   (evt)
    );

    psram_win_timer #(.WIN_CYC(WIN_CYC)) u_win (
        .clk    (clk),
        .rst_n  (rst_n),
        .evt    (evt),
        .frozen (wr_cyc),
        .expire (expire)
    );

    psram_viol_recorder #(.CNT_W(CNT_W)) u_rec (
        .clk    (clk),
        .rst_n  (rst_n),
        .expire (expire),
        .clr    (viol_clr),
        .flag   (viol_flag),
        .count  (viol_count)
    );

endmodule

// File: tb/psram_refresh_monitor_test.sv
`timescale 1ns/1ps
module psram_refresh_monitor_test;
    localparam int AW = 17, CW = 2;
    localparam int TRC = 18, WIN = 3750, CMAX = 3;

    logic clk = 0, rst_n = 0, ce_n = 1, we_n = 1, clr = 0;
    logic [AW-1:0] addr = '0;
    logic flag;
    logic [CW-1:0] cnt;
    int n_tests = 0, n_fail = 0;

    always #2 clk = ~clk;

    psram_refresh_monitor #(.ADDR_W(AW), .CNT_W(CW)) uut (
        .clk(clk), .rst_n(rst_n), .mem_ce_n(ce_n), .mem_we_n(we_n),
        .mem_addr(addr), .viol_clr(clr), .viol_flag(flag), .viol_count(cnt));

    // behavioural reference: run lengths and window age as plain integers
    int m_held, m_hi, m_age, m_cnt;
    logic [AW-1:0] m_prev;
    logic m_on, m_flag, m_rst, m_start, m_exp;
    always @(posedge clk) begin
        if (!rst_n) begin
            m_held = 0; m_hi = 0; m_age = 0; m_cnt = 0; m_prev = '0;
            m_on = 0; m_flag = 0;
        end else begin
            m_rst = 0; m_start = 0; m_exp = 0;
            if (ce_n) begin
                m_held = 0; m_prev = addr; m_hi = m_hi + 1;
                if (m_hi == TRC) m_rst = 1;
            end else if (!we_n) begin
                m_hi = 0;
            end else begin
                m_hi = 0;
                if (m_held == 0) m_held = 1;
                else if (addr != m_prev) begin
                    if (m_held < TRC) m_start = 1;
                    m_held = 1;
                end else begin
                    m_held = m_held + 1;
                    if (m_held == TRC) m_rst = 1;
                end
                m_prev = addr;
            end
            if (m_rst) begin m_on = 0; m_age = 0; end
            else if (m_on && !(!ce_n && !we_n)) begin
                m_age = m_age + 1;
                if (m_age == WIN) begin m_exp = 1; m_on = 0; m_age = 0; end
            end else if (!m_on && m_start) begin m_on = 1; m_age = 0; end
            if (m_exp) begin m_flag = 1; if (m_cnt < CMAX) m_cnt = m_cnt + 1; end
            else if (clr) m_flag = 0;
        end
    end

    // per-clock comparison against the model (R2 R3 R4 R5 R6 R7 R8)
    always @(negedge clk) if (rst_n) begin
        n_tests++;
        if (flag !== m_flag || int'(cnt) != m_cnt) begin
            n_fail++;
            $display("FAIL R3/R7/R8 model t=%0t flag=%0b cnt=%0d expected flag=%0b cnt=%0d",
                     $time, flag, cnt, m_flag, m_cnt);
        end
    end

    logic seen_flag = 0;
    always @(negedge clk) if (flag) seen_flag = 1;

    task automatic check(input string req, input int act, input int exp);
        n_tests++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic reads(input int n, input int per);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            ce_n = 0; we_n = 1;
            if (i % per == 0) addr = addr + 1;
        end
    endtask

    task automatic writes(input int n, input int per);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            ce_n = 0; we_n = 0;
            if (i % per == 0) addr = addr + 3;
        end
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            ce_n = 1; we_n = 1;
        end
    endtask

    task automatic pulse_clr();
        @(negedge clk); clr = 1;
        @(negedge clk); clr = 0;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog expired");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        check("R1 flag after reset", flag, 0);
        check("R1 count after reset", cnt, 0);

        // R2/R3: continuous fast reads exceed the window
        reads(4000, 5); idle(30);
        check("R3 flag after long fast run", flag, 1);
        check("R8 count after first violation", cnt, 1);

        pulse_clr(); @(negedge clk);
        check("R7 flag cleared", flag, 0);
        check("R7 clear keeps count", cnt, 1);

        // R4: one full-length read recovers
        reads(3000, 5); reads(18, 100); reads(3000, 5); idle(30);
        check("R4 normal read restarts window", flag, 0);

        // R5: short gap does not recover
        reads(3000, 5); idle(10); reads(1000, 5); idle(30);
        check("R5 short gap no restart", flag, 1);
        check("R8 count two", cnt, 2);
        pulse_clr();

        // R5: full gap recovers
        reads(3000, 5); idle(20); reads(3000, 5); idle(30);
        check("R5 long gap restarts window", flag, 0);

        // R6: writes do not age the window
        reads(2000, 5); writes(3000, 4); reads(1000, 5); idle(30);
        check("R6 write does not extend", flag, 0);

        // R6: writes do not recover the window
        reads(3000, 5); writes(100, 50); reads(1000, 5); idle(30);
        check("R6 write does not restart", flag, 1);
        check("R8 count three", cnt, 3);
        pulse_clr();

        // R2 boundary: 18-cycle holds are valid reads
        reads(4000, 18); idle(30);
        check("R2 hold of TRC cycles valid", flag, 0);

        // R2 boundary: 17-cycle holds are invalid; clr held high, R7 set wins
        seen_flag = 0;
        @(negedge clk); clr = 1;
        reads(4000, 17); idle(30);
        check("R7 flag rose despite clear", seen_flag, 1);
        check("R7 flag cleared by held clear", flag, 0);
        check("R8 count saturates", cnt, 3);
        clr = 0;
        idle(5);

        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule